// File: doc/BRIEF.md
# Timer Interrupt Gate with Shared Factor Flag

This block sits between a calendar timer and the CPU interrupt logic. The timer supplies two event pulses: a periodic tick and an alarm match. Each pulse sets its own sticky status flag. The select bits decide which sources also set a single shared factor flag. An enable bit gates that factor flag into an interrupt request. A programmed 3-bit level is then compared with the CPU's global enable and current interrupt level to decide whether the request would be accepted.

Software reads both status flags to learn which source fired. It clears the flags by writing ones. The block also presents the trap vector address for this source, which is computed from a relocatable table base. The register port is a simple single-cycle write strobe with a combinational read. This interrupt source has no DMA request output.

Top module: `tig_irq_gate`

## Requirements
- R1: After a synchronous active-low reset, all flags, the enable, both select bits and the level read as 0. The table base reads 0x00C00000, and `vec_addr` is 0x00C00104.
- R2: A pulse on `tick_evt` sets the tick status flag (address 0, bit 0) on the next clock edge. A pulse on `alarm_evt` sets the alarm status flag (address 0, bit 1). Both happen whatever the values of the enable and select bits, and each flag then stays at 1.
- R3: A write to address 0 clears each status or factor flag whose data bit is 1. A data bit of 0 leaves the corresponding flag unchanged.
- R4: The factor flag (address 0, bit 2) is set on the next edge by a tick pulse when the tick select bit (address 1, bit 1) is 1. It is set by an alarm pulse when the alarm select bit (address 1, bit 2) is 1. A pulse from a deselected source does not set it. None of this depends on the enable bit.
- R5: When a source event and a clearing write hit the same flag in the same cycle, the flag ends at 1.
- R6: `irq_req` is 1 exactly when both the factor flag and the enable bit (address 1, bit 0) are 1.
- R7: `irq_level` equals the level field (address 1, bits 6:4). `irq_accept` is 1 exactly when `irq_req` is 1, `cpu_ie` is 1 and `cpu_il` is strictly less than the level.
- R8: A write to address 2 loads the table base. `vec_addr` always equals the base plus 0x104, modulo 2^32.
- R9: Address 1 reads back enable, tick select, alarm select and level in the bit positions given above, with all other bits 0. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| tick_evt | input | 1 | Periodic tick event pulse |
| alarm_evt | input | 1 | Alarm match event pulse |
| cpu_ie | input | 1 | CPU global interrupt enable |
| cpu_il | input | 3 | CPU current interrupt level |
| irq_req | output | 1 | Interrupt request |
| irq_accept | output | 1 | Request would be accepted by the CPU |
| irq_level | output | 3 | Programmed interrupt level |
| vec_addr | output | 32 | Trap vector address for this source |

## Verification
A status or factor flag held in the wrong state shows up at address 0 on the very next read. For the factor flag, it also shows on `irq_req` in the cycle after the faulty edge. A wrong priority of set over clear is caught by driving an event and a clearing write in the same cycle, then comparing the flags in the following cycle. Level comparison errors show at once on `irq_accept`, and they are probed at the equal-level boundary. A corrupted base shows on `vec_addr` immediately.

// File: rtl/tig_pkg.sv
// Shared constants and types for the timer interrupt gate.
// Assumes a 2-bit register address space and a 32-bit data path.
package tig_pkg;
    localparam int NSRC    = 2;
    localparam int LVL_W   = 3;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 2;
    localparam int SRC_TICK  = 0;
    localparam int SRC_ALARM = 1;
    localparam int FAC_BIT   = NSRC;
    localparam int LVL_LSB   = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_STAT = 2'd0,
        A_CTRL = 2'd1,
        A_BASE = 2'd2,
        A_RSVD = 2'd3
    } tig_addr_e;

    typedef struct packed {
        logic [LVL_W-1:0] lvl;
        logic [NSRC-1:0]  sel;
        logic             en;
    } tig_ctrl_t;
endpackage

// File: rtl/tig_src_flags.sv
// Sticky per-source status flags and the shared factor flag.
// Assumes event pulses and clear requests are synchronous to clk.
// In every flag, a set in the same cycle overrides a clear.
module tig_src_flags
    import tig_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] sel,
    input  logic [N-1:0] clr_src,
    input  logic         clr_fac,
    output logic [N-1:0] src_flag,
    output logic         fac_flag
);
    logic fac_set;

    for (genvar i = 0; i < N; i++) begin : g_src
        // Purpose: hold one source status flag, set by its event and cleared by software.
        always_ff @(posedge clk) begin
            if (!rst_n)          src_flag[i] <= 1'b0;
            else if (evt[i])     src_flag[i] <= 1'b1;
            else if (clr_src[i]) src_flag[i] <= 1'b0;
        end
    end

    // Purpose: the factor flag is set by any event from a selected source.
    always_comb fac_set = |(evt & sel);

    // Purpose: hold the shared factor flag.
    always_ff @(posedge clk) begin
        if (!rst_n)       fac_flag <= 1'b0;
        else if (fac_set) fac_flag <= 1'b1;
        else if (clr_fac) fac_flag <= 1'b0;
    end
endmodule

// File: rtl/tig_regs.sv
// Control and table-base registers, plus decoding of the clearing writes to the status word.
// Assumes a one-cycle write strobe.
module tig_regs
    import tig_pkg::*;
#(
    parameter logic [DATA_W-1:0] BASE_RST = 32'h00C0_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output tig_ctrl_t         ctrl,
    output logic [DATA_W-1:0] base,
    output logic [NSRC-1:0]   clr_src,
    output logic              clr_fac
);
    logic wr_stat, wr_ctrl, wr_base;

    // Purpose: decode the write strobe into per-register writes.
    always_comb begin
        wr_stat = wr && (tig_addr_e'(addr) == A_STAT);
        wr_ctrl = wr && (tig_addr_e'(addr) == A_CTRL);
        wr_base = wr && (tig_addr_e'(addr) == A_BASE);
    end

    // Purpose: turn the ones written to the status word into clear requests.
    always_comb begin
        clr_src = wr_stat ? wdata[NSRC-1:0] : '0;
        clr_fac = wr_stat && wdata[FAC_BIT];
    end

    // Purpose: hold the control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_ctrl) begin
            ctrl.en  <= wdata[0];
            ctrl.sel <= wdata[NSRC:1];
            ctrl.lvl <= wdata[LVL_LSB +: LVL_W];
        end
    end

    // Purpose: hold the relocatable trap table base.
    always_ff @(posedge clk) begin
        if (!rst_n)       base <= BASE_RST;
        else if (wr_base) base <= wdata;
    end
endmodule

// File: rtl/tig_gate.sv
// Request gating, CPU acceptance test and vector address generation.
// Purely combinational. Assumes the CPU level and enable are stable within a cycle.
module tig_gate
    import tig_pkg::*;
#(
    parameter logic [DATA_W-1:0] VEC_OFS = 32'h0000_0104
) (
    input  logic              fac_flag,
    input  tig_ctrl_t         ctrl,
    input  logic [DATA_W-1:0] base,
    input  logic              cpu_ie,
    input  logic [LVL_W-1:0]  cpu_il,
    output logic              irq_req,
    output logic              irq_accept,
    output logic [DATA_W-1:0] vec_addr
);
    // Purpose: the enable gates the factor flag into a request.
    always_comb irq_req = fac_flag && ctrl.en;

    // Purpose: accept only when the CPU's current level is strictly below the programmed one.
    always_comb irq_accept = irq_req && cpu_ie && (cpu_il < ctrl.lvl);

    // Purpose: place the vector at a fixed offset from the table base.
    always_comb vec_addr = base + VEC_OFS;
endmodule

// File: rtl/tig_irq_gate.sv
// Top level of the timer interrupt gate: source flags, registers, gating and the read mux.
// Assumes a single clock domain and a synchronous active-low reset.
module tig_irq_gate
    import tig_pkg::*;
#(
    parameter logic [DATA_W-1:0] BASE_RST = 32'h00C0_0000,
    parameter logic [DATA_W-1:0] VEC_OFS  = 32'h0000_0104
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              tick_evt,
    input  logic              alarm_evt,
    input  logic              cpu_ie,
    input  logic [LVL_W-1:0]  cpu_il,
    output logic              irq_req,
    output logic              irq_accept,
    output logic [LVL_W-1:0]  irq_level,
    output logic [DATA_W-1:0] vec_addr
);
    tig_ctrl_t         ctrl_q;
    logic [DATA_W-1:0] base_q;
    logic [NSRC-1:0]   clr_src;
    logic              clr_fac;
    logic [NSRC-1:0]   src_flag;
    logic              fac_flag;
    logic [NSRC-1:0]   evt;

    // Purpose: collect the event pulses into a vector indexed by source.
    always_comb begin
        evt            = '0;
        evt[SRC_TICK]  = tick_evt;
        evt[SRC_ALARM] = alarm_evt;
    end

    tig_regs #(.BASE_RST(BASE_RST)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .ctrl    (ctrl_q),
        .base    (base_q),
        .clr_src (clr_src),
        .clr_fac (clr_fac)
    );

    tig_src_flags #(.N(NSRC)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .sel      (ctrl_q.sel),
        .clr_src  (clr_src),
        .clr_fac  (clr_fac),
        .src_flag (src_flag),
        .fac_flag (fac_flag)
    );

    tig_gate #(.VEC_OFS(VEC_OFS)) u_gate (
        .fac_flag   (fac_flag),
        .ctrl       (ctrl_q),
        .base       (base_q),
        .cpu_ie     (cpu_ie),
        .cpu_il     (cpu_il),
        .irq_req    (irq_req),
        .irq_accept (irq_accept),
        .vec_addr   (vec_addr)
    );

    // Purpose: expose the programmed level.
    always_comb irq_level = ctrl_q.lvl;

    // Purpose: select the register addressed for reading.
    always_comb begin
        reg_rdata = '0;
        unique case (tig_addr_e'(reg_addr))
            A_STAT: begin
                reg_rdata[NSRC-1:0] = src_flag;
                reg_rdata[FAC_BIT]  = fac_flag;
            end
            A_CTRL: begin
                reg_rdata[0]                 = ctrl_q.en;
                reg_rdata[NSRC:1]            = ctrl_q.sel;
                reg_rdata[LVL_LSB +: LVL_W]  = ctrl_q.lvl;
            end
            A_BASE: reg_rdata = base_q;
            A_RSVD: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tig_chk.sv
// Assertion checker for tig_irq_gate, attached through bind.
// Observes ports plus the internal flags and select bits.
module tig_chk
    import tig_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              tick_evt,
    input logic              alarm_evt,
    input logic              cpu_ie,
    input logic [LVL_W-1:0]  cpu_il,
    input logic              irq_req,
    input logic              irq_accept,
    input logic [LVL_W-1:0]  irq_level,
    input logic [DATA_W-1:0] vec_addr,
    input logic [NSRC-1:0]   src_flag,
    input logic              fac_flag,
    input logic [NSRC-1:0]   sel
);
    logic clr_tick_wr, fac_hit, base_wr;

    always_comb begin
        clr_tick_wr = reg_wr && (reg_addr == 2'd0) && reg_wdata[0];
        fac_hit     = (tick_evt && sel[SRC_TICK]) || (alarm_evt && sel[SRC_ALARM]);
        base_wr     = reg_wr && (reg_addr == 2'd2);
    end

    AST_TICK_SETS:  assert property (@(posedge clk) disable iff (!rst_n) tick_evt |=> src_flag[SRC_TICK]);   // R2
    AST_ALARM_SETS: assert property (@(posedge clk) disable iff (!rst_n) alarm_evt |=> src_flag[SRC_ALARM]); // R2
    AST_TICK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (src_flag[SRC_TICK] && !clr_tick_wr) |=> src_flag[SRC_TICK]); // R3
    AST_FAC_SETS:   assert property (@(posedge clk) disable iff (!rst_n) fac_hit |=> fac_flag);  // R4
    AST_FAC_QUIET:  assert property (@(posedge clk) disable iff (!rst_n) (!fac_flag && !fac_hit) |=> !fac_flag); // R4
    AST_REQ_NEEDS_FAC: assert property (@(posedge clk) disable iff (!rst_n) irq_req |-> fac_flag); // R6
    AST_ACCEPT_GATE: assert property (@(posedge clk) disable iff (!rst_n) irq_accept |-> (irq_req && cpu_ie && (cpu_il < irq_level))); // R7
    AST_VEC_STABLE: assert property (@(posedge clk) disable iff (!rst_n) !base_wr |=> $stable(vec_addr)); // R8
endmodule

bind tig_irq_gate tig_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .tick_evt   (tick_evt),
    .alarm_evt  (alarm_evt),
    .cpu_ie     (cpu_ie),
    .cpu_il     (cpu_il),
    .irq_req    (irq_req),
    .irq_accept (irq_accept),
    .irq_level  (irq_level),
    .vec_addr   (vec_addr),
    .src_flag   (src_flag),
    .fac_flag   (fac_flag),
    .sel        (ctrl_q.sel)
);

// File: tb/tig_irq_gate_tb.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases followed by seeded random stimulus, all compared
// against a reference model built from the requirements.
module tig_irq_gate_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        tick_evt, alarm_evt, cpu_ie;
    logic [2:0]  cpu_il;
    logic        irq_req, irq_accept;
    logic [2:0]  irq_level;
    logic [31:0] vec_addr;

    int n_tests = 0;
    int n_fail  = 0;

    // Reference model state.
    bit        m_tf, m_af, m_ff, m_en, m_st, m_sa;
    bit [2:0]  m_lv;
    bit [31:0] m_base;

    always #2.5 clk = ~clk;

    tig_irq_gate u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_evt(tick_evt),
        .alarm_evt(alarm_evt), .cpu_ie(cpu_ie), .cpu_il(cpu_il),
        .irq_req(irq_req), .irq_accept(irq_accept), .irq_level(irq_level),
        .vec_addr(vec_addr)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic bit [31:0] exp_rdata(bit [1:0] a);
        case (a)
            2'd0:    return {29'd0, m_ff, m_af, m_tf};
            2'd1:    return {25'd0, m_lv, 1'b0, m_sa, m_st, m_en};
            2'd2:    return m_base;
            default: return 32'd0;
        endcase
    endfunction

    function automatic bit exp_req();
        return m_ff && m_en;
    endfunction

    function automatic bit exp_acc(bit ie, bit [2:0] il);
        return exp_req() && ie && (il < m_lv);
    endfunction

    task automatic model_reset();
        m_tf = 0; m_af = 0; m_ff = 0; m_en = 0; m_st = 0; m_sa = 0; m_lv = 0;
        m_base = 32'h00C0_0000;
    endtask

    // Drive inputs at the falling edge, check the outputs, then advance the model across one rising edge.
    task automatic step(bit wr, bit [1:0] a, bit [31:0] wd, bit t, bit al, bit ie, bit [2:0] il);
        bit n_tf, n_af, n_ff, clr;
        reg_wr = wr; reg_addr = a; reg_wdata = wd;
        tick_evt = t; alarm_evt = al; cpu_ie = ie; cpu_il = il;
        #1;
        chk("R6", "irq_req", {31'd0, irq_req}, {31'd0, exp_req()});
        chk("R7", "irq_accept", {31'd0, irq_accept}, {31'd0, exp_acc(ie, il)});
        chk("R7", "irq_level", {29'd0, irq_level}, {29'd0, m_lv});
        chk("R8", "vec_addr", vec_addr, m_base + 32'h104);
        case (a)
            2'd0: chk("R2 R3 R4 R5", "status read", reg_rdata, exp_rdata(a));
            2'd2: chk("R8", "base read", reg_rdata, exp_rdata(a));
            default: chk("R9", "ctrl/reserved read", reg_rdata, exp_rdata(a));
        endcase
        clr  = wr && (a == 2'd0);
        n_tf = t  ? 1'b1 : ((clr && wd[0]) ? 1'b0 : m_tf);
        n_af = al ? 1'b1 : ((clr && wd[1]) ? 1'b0 : m_af);
        n_ff = ((t && m_st) || (al && m_sa)) ? 1'b1 : ((clr && wd[2]) ? 1'b0 : m_ff);
        @(posedge clk);
        m_tf = n_tf; m_af = n_af; m_ff = n_ff;
        if (wr && a == 2'd1) begin
            m_en = wd[0]; m_st = wd[1]; m_sa = wd[2]; m_lv = wd[6:4];
        end
        if (wr && a == 2'd2) m_base = wd;
        @(negedge clk);
    endtask

    task automatic idle_read(bit [1:0] a);
        step(0, a, 32'd0, 0, 0, 0, 3'd0);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
        tick_evt = 0; alarm_evt = 0; cpu_ie = 0; cpu_il = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        model_reset();

        // R1: reset state seen at the ports.
        reg_addr = 2'd0; #1;
        chk("R1", "status after reset", reg_rdata, 32'd0);
        reg_addr = 2'd1; #1;
        chk("R1", "ctrl after reset", reg_rdata, 32'd0);
        reg_addr = 2'd2; #1;
        chk("R1", "base after reset", reg_rdata, 32'h00C0_0000);
        chk("R1", "vector after reset", vec_addr, 32'h00C0_0104);
        chk("R1", "irq_req after reset", {31'd0, irq_req}, 32'd0);

        // R2, R4: events with nothing selected set the status flags but not the factor flag.
        step(0, 2'd0, 0, 1, 0, 0, 0);
        step(0, 2'd0, 0, 0, 1, 0, 0);
        step(0, 2'd0, 0, 0, 0, 0, 0);
        chk("R2", "both status flags", reg_rdata, 32'h3);
        chk("R4", "factor stays clear when deselected", {31'd0, reg_rdata[2]}, 32'd0);

        // R3: a write of 0 leaves the flags unchanged, a write of 1 clears only that flag.
        step(1, 2'd0, 32'h0, 0, 0, 0, 0);
        step(1, 2'd0, 32'h1, 0, 0, 0, 0);
        step(0, 2'd0, 0, 0, 0, 0, 0);
        chk("R3", "selective clear", reg_rdata, 32'h2);

        // R4: select the alarm only, with the enable off; the factor sets but no request appears.
        step(1, 2'd1, 32'h0000_0044, 0, 0, 0, 0);
        step(0, 2'd0, 0, 1, 0, 0, 0);
        step(0, 2'd0, 0, 0, 0, 0, 0);
        chk("R4", "tick not selected", {31'd0, reg_rdata[2]}, 32'd0);
        step(0, 2'd0, 0, 0, 1, 0, 0);
        step(0, 2'd0, 0, 0, 0, 0, 0);
        chk("R4", "alarm selected sets factor", {31'd0, reg_rdata[2]}, 32'd1);
        chk("R6", "no request while disabled", {31'd0, irq_req}, 32'd0);

        // R5: an event and a clearing write on the same cycle leave the flag set.
        step(1, 2'd0, 32'h7, 0, 1, 0, 0);
        step(0, 2'd0, 0, 0, 0, 0, 0);
        chk("R5", "set beats clear", reg_rdata, 32'h6);

        // R7: equal level is refused, a lower CPU level is accepted, a global disable blocks it.
        step(1, 2'd1, 32'h0000_0045, 0, 0, 0, 0);
        step(0, 2'd1, 0, 0, 0, 1, 3'd4);
        chk("R7", "equal level refused", {31'd0, irq_accept}, 32'd0);
        step(0, 2'd1, 0, 0, 0, 1, 3'd3);
        chk("R9", "ctrl readback", reg_rdata, 32'h45);
        step(0, 2'd1, 0, 0, 0, 0, 3'd0);

        // R8: relocate the table base, including wrap-around.
        step(1, 2'd2, 32'h1234_5000, 0, 0, 0, 0);
        idle_read(2'd2);
        chk("R8", "relocated vector", vec_addr, 32'h1234_5104);
        step(1, 2'd2, 32'hFFFF_FF00, 0, 0, 0, 0);
        idle_read(2'd3);
        chk("R8", "vector wraps", vec_addr, 32'h0000_0004);
        chk("R9", "reserved reads zero", reg_rdata, 32'd0);

        // Random phase: the model check inside step covers R2 to R9.
        for (int i = 0; i < 3000; i++) begin
            bit [1:0]  a  = 2'($urandom_range(0, 3));
            bit        wr = ($urandom_range(0, 3) == 0);
            bit [31:0] wd = $urandom;
            if (wr && a == 2'd2 && $urandom_range(0, 3) != 0) wr = 0;
            step(wr, a, wd, ($urandom_range(0, 4) == 0), ($urandom_range(0, 4) == 0),
                 1'($urandom), 3'($urandom));
        end

        finish_run();
    end
endmodule